// File: doc/BRIEF.md
# Single-Shot Frame Capture Buffer

This block grabs one whole video frame at the full pixel rate into an external memory and then holds it. A slow controller on its own clock reads it back one word at a time. Capture starts only at a frame-start marker that arrives after the buffer is armed. Writes go to consecutive addresses from zero, and every word presented with the data-valid input is stored, blanking samples included. Writing stops once the configured frame length has been stored. Any frames that arrive afterwards are dropped without error until the controller asks for a new frame. If the memory is smaller than the frame, capture stops at the last address and a truncation flag is raised.

The readout side shows a frame-ready flag, an empty flag and the word at the current read address. A read strobe moves to the next word. A rearm command from the controller releases the held frame. Rearm is honoured only while a frame is held. It returns the address to zero and lets the capture side wait for the next frame start. The held-frame flag, the rearm request and its acknowledge cross between the two clocks through two-flop synchronisers with level handshakes. The captured length and the truncation bit are sampled only while they are frozen.

Top module: `frame_grab_buf`

## Requirements
- R1: After reset, `rd_frame_ready` is 0, `rd_empty` is 1, `rd_truncated` is 0 and no memory write takes place.
- R2: Once armed, the first write happens on the first cycle where `pix_valid` and `pix_sof` are both 1, and it goes to address 0. Valid words before that marker are never written.
- R3: During capture, each cycle with `pix_valid`=1 writes `pix_data` to the address one above the previous write. Cycles with `pix_valid`=0 write nothing and do not advance the address.
- R4: Writing stops after FRAME_WORDS words, or after 2**ADDR_W words if that is fewer. Later frames, including frames that arrive during a drain, cause no write until a rearm.
- R5: After capture ends, `rd_frame_ready` rises, and `rd_data` shows the word stored at the current read address, starting from address 0.
- R6: With the frame held and not empty, a read strobe advances `mem_raddr` by one. `rd_empty` becomes 1 exactly when the captured word count has been read, and strobes while empty change nothing.
- R7: `rd_rearm` is ignored while no frame is held: `rd_frame_ready` stays 0 and a later capture proceeds as normal.
- R8: `rd_rearm` while a frame is held (read or partly read) drops `rd_frame_ready` on the next read clock edge and clears `rd_truncated`. The next captured frame is then stored from address 0 again.
- R9: When FRAME_WORDS exceeds 2**ADDR_W, capture stops after writing address 2**ADDR_W-1, `rd_truncated` is 1 with the frame, and the held length is 2**ADDR_W words.
- R10: Words with `pix_valid`=1 are stored whatever their value, including all-zero blanking samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Fast capture clock |
| pix_rst_n | input | 1 | Active-low reset, capture side |
| pix_valid | input | 1 | Input word is present |
| pix_sof | input | 1 | Input word is the first of a frame |
| pix_data | input | DATA_W | Input word |
| mem_we | output | 1 | Memory write enable (pix_clk) |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| rd_clk | input | 1 | Slow readout clock |
| rd_rst_n | input | 1 | Active-low reset, readout side |
| rd_strobe | input | 1 | Advance to the next stored word |
| rd_rearm | input | 1 | Release the held frame and wait for the next one |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data for `mem_raddr` |
| rd_data | output | DATA_W | Word at the current read address |
| rd_empty | output | 1 | No unread word remains |
| rd_frame_ready | output | 1 | A captured frame is held |
| rd_truncated | output | 1 | The held frame was cut short by memory depth |

## Verification
Two copies run on the same stream. In one the frame fits the memory, and in the other it overruns it, so full and truncated captures are compared word by word against values the bench computes from frame tag and index. The stimulus includes a tail of a frame without a start marker, frames with idle gaps, and frames whose leading words are zero. These separate a capture that waits for the marker from one that starts at once, and a pointer that skips idle cycles from one that counts them. A further frame is sent while the drain is running, and extra strobes are issued after the last word, to show that the held data and read pointer are never touched. Rearm is tried with no frame held, after a full drain, and part-way through a drain.

// File: rtl/fgb_pkg.sv
package fgb_pkg;

  typedef enum logic [1:0] {
    CAP_ARMED = 2'd0,
    CAP_RUN   = 2'd1,
    CAP_HOLD  = 2'd2,
    CAP_CLEAR = 2'd3
  } cap_state_t;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_READY = 2'd1,
    RD_DRAIN = 2'd2,
    RD_REARM = 2'd3
  } rd_state_t;

  // Number of words a capture holds: the frame, or the memory if smaller.
  function automatic int unsigned held_words(input int unsigned frame_words,
                                             input int unsigned depth);
    return (frame_words < depth) ? frame_words : depth;
  endfunction

  // True when writing word index idx completes the capture.
  function automatic logic capture_ends(input int unsigned idx,
                                        input int unsigned frame_words,
                                        input int unsigned depth);
    return (idx + 1) >= held_words(frame_words, depth);
  endfunction

  // True when a capture ending at idx fell short of the frame.
  function automatic logic cut_short(input int unsigned idx,
                                     input int unsigned frame_words);
    return (idx + 1) < frame_words;
  endfunction

endpackage

// File: rtl/fgb_sync.sv
module fgb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/fgb_capture.sv
module fgb_capture
  import fgb_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 163840,
  localparam int LEN_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              sof,
  input  logic [DATA_W-1:0] data,
  input  logic              req_s,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              done_q,
  output logic              ack_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              trunc_q,
  output logic              start_evt,
  output logic              end_evt,
  output cap_state_t        state
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  cap_state_t        st_n;
  logic [ADDR_W-1:0] wa;

  always_comb begin
    we        = valid && ((state == CAP_ARMED && sof) || state == CAP_RUN);
    waddr     = (state == CAP_ARMED) ? '0 : wa;
    wdata     = data;
    start_evt = we && (state == CAP_ARMED);
    end_evt   = we && capture_ends(int'(waddr), FRAME_WORDS, DEPTH);
    st_n      = state;
    case (state)
      CAP_ARMED: if (we) st_n = end_evt ? CAP_HOLD : CAP_RUN;
      CAP_RUN:   if (end_evt) st_n = CAP_HOLD;
      CAP_HOLD:  if (req_s) st_n = CAP_CLEAR;
      CAP_CLEAR: if (!req_s) st_n = CAP_ARMED;
      default:   st_n = CAP_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CAP_ARMED;
      wa      <= '0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      len_q   <= '0;
      trunc_q <= 1'b0;
    end else begin
      state  <= st_n;
      done_q <= (st_n == CAP_HOLD);
      ack_q  <= (st_n == CAP_CLEAR);
      if (we && !end_evt) wa <= waddr + 1'b1;
      if (end_evt) begin
        len_q   <= LEN_W'(waddr) + 1'b1;
        trunc_q <= cut_short(int'(waddr), FRAME_WORDS);
      end
    end
  end
endmodule

// File: rtl/fgb_drain.sv
module fgb_drain
  import fgb_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              rearm,
  input  logic              done_s,
  input  logic              ack_s,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              trunc_in,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              frame_ready,
  output logic              truncated,
  output logic              req_q,
  output logic              take_evt,
  output rd_state_t         state
);
  logic [LEN_W-1:0] ra;
  logic [LEN_W-1:0] len;
  logic             held;

  always_comb begin
    held        = (state == RD_READY) || (state == RD_DRAIN);
    frame_ready = held;
    empty       = !held || (ra == len);
    take_evt    = held && strobe && !empty && !rearm;
    raddr       = ra[ADDR_W-1:0];
    rd_data     = rdata_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RD_IDLE;
      ra        <= '0;
      len       <= '0;
      truncated <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      case (state)
        RD_IDLE: if (done_s) begin
          state     <= RD_READY;
          ra        <= '0;
          len       <= len_in;
          truncated <= trunc_in;
        end
        RD_READY, RD_DRAIN: begin
          if (rearm) begin
            state     <= RD_REARM;
            req_q     <= 1'b1;
            truncated <= 1'b0;
          end else if (take_evt) begin
            state <= RD_DRAIN;
            ra    <= ra + 1'b1;
          end
        end
        RD_REARM: if (ack_s) begin
          state <= RD_IDLE;
          req_q <= 1'b0;
          ra    <= '0;
        end
        default: state <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_grab_buf.sv
module frame_grab_buf
  import fgb_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 163840
) (
  input  logic              pix_clk,
  input  logic              pix_rst_n,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic [DATA_W-1:0] pix_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_strobe,
  input  logic              rd_rearm,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_frame_ready,
  output logic              rd_truncated
);
  localparam int LEN_W = ADDR_W + 1;

  logic             done_q, ack_q, req_q;
  logic             done_s, ack_s, req_s;
  logic [LEN_W-1:0] len_q;
  logic             trunc_q;
  logic             cap_start_evt, cap_end_evt, rd_take_evt;
  cap_state_t       cap_st;
  rd_state_t        drain_st;

  fgb_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_WORDS(FRAME_WORDS)) u_cap (
    .clk(pix_clk), .rst_n(pix_rst_n), .valid(pix_valid), .sof(pix_sof),
    .data(pix_data), .req_s(req_s), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .done_q(done_q), .ack_q(ack_q), .len_q(len_q),
    .trunc_q(trunc_q), .start_evt(cap_start_evt), .end_evt(cap_end_evt),
    .state(cap_st)
  );

  fgb_sync #(.W(2)) u_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .d({done_q, ack_q}), .q({done_s, ack_s})
  );

  fgb_sync #(.W(1)) u_to_pix (
    .clk(pix_clk), .rst_n(pix_rst_n), .d(req_q), .q(req_s)
  );

  fgb_drain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drain (
    .clk(rd_clk), .rst_n(rd_rst_n), .strobe(rd_strobe), .rearm(rd_rearm),
    .done_s(done_s), .ack_s(ack_s), .len_in(len_q), .trunc_in(trunc_q),
    .rdata_in(mem_rdata), .raddr(mem_raddr), .rd_data(rd_data),
    .empty(rd_empty), .frame_ready(rd_frame_ready), .truncated(rd_truncated),
    .req_q(req_q), .take_evt(rd_take_evt), .state(drain_st)
  );
endmodule

// File: rtl/fgb_checker.sv
module fgb_checker
  import fgb_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int FRAME_WORDS = 163840
) (
  input logic              pix_clk,
  input logic              pix_rst_n,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              pix_sof,
  input cap_state_t        cap_st,
  input logic              cap_start_evt,
  input logic              rd_strobe,
  input logic              rd_rearm,
  input logic              rd_empty,
  input logic              rd_frame_ready,
  input logic [ADDR_W-1:0] mem_raddr,
  input rd_state_t         drain_st
);
  logic [ADDR_W-1:0] last_wa;
  always_ff @(posedge pix_clk or negedge pix_rst_n) begin
    if (!pix_rst_n) last_wa <= '0;
    else if (mem_we) last_wa <= mem_waddr;
  end

  p_first_at_zero_r2: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    cap_start_evt |-> (pix_sof && mem_waddr == '0));

  p_seq_addr_r3: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    (mem_we && cap_st == CAP_RUN) |-> (mem_waddr == last_wa + 1'b1));

  p_no_write_held_r4: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    (cap_st == CAP_HOLD || cap_st == CAP_CLEAR) |-> !mem_we);

  p_addr_bound_r9: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    mem_we |-> (int'(mem_waddr) < FRAME_WORDS));

  p_read_step_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_frame_ready && rd_strobe && !rd_empty && !rd_rearm)
      |=> (mem_raddr == $past(mem_raddr) + 1'b1));

  p_empty_holds_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_frame_ready && rd_empty && !rd_rearm) |=> ($stable(mem_raddr) && rd_empty));

  p_rearm_ignored_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (drain_st == RD_IDLE && rd_rearm) |=> (drain_st != RD_REARM));

  p_ready_drops_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_frame_ready && rd_rearm) |=> !rd_frame_ready);
endmodule

bind frame_grab_buf fgb_checker #(.ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS)) u_chk (
  .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .pix_sof(pix_sof), .cap_st(cap_st),
  .cap_start_evt(cap_start_evt), .rd_strobe(rd_strobe), .rd_rearm(rd_rearm),
  .rd_empty(rd_empty), .rd_frame_ready(rd_frame_ready), .mem_raddr(mem_raddr),
  .drain_st(drain_st)
);

// File: tb/tb_frame_grab_buf.sv
`timescale 1ns/1ps
module tb_frame_grab_buf;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int DEPTH = 2 ** AW;
  localparam int LEN_A = 20;
  localparam int LEN_B = DEPTH;

  logic pix_clk = 0, rd_clk = 0;
  logic pix_rst_n = 0, rd_rst_n = 0;
  logic pix_valid = 0, pix_sof = 0;
  logic [DW-1:0] pix_data = '0;
  logic rd_strobe = 0, rd_rearm = 0;

  logic we_a, we_b;
  logic [AW-1:0] wa_a, wa_b, ra_a, ra_b;
  logic [DW-1:0] wd_a, wd_b, rdd_a, rdd_b;
  logic emp_a, emp_b, rdy_a, rdy_b, tr_a, tr_b;
  logic [DW-1:0] mem_a [DEPTH];
  logic [DW-1:0] mem_b [DEPTH];
  int wcnt_a = 0, wcnt_b = 0;
  int n_chk = 0, n_err = 0;

  always #2 pix_clk = ~pix_clk;
  always #14 rd_clk = ~rd_clk;

  frame_grab_buf #(.ADDR_W(AW), .DATA_W(DW), .FRAME_WORDS(LEN_A)) dut (
    .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_data(pix_data), .mem_we(we_a), .mem_waddr(wa_a), .mem_wdata(wd_a),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_strobe(rd_strobe), .rd_rearm(rd_rearm),
    .mem_raddr(ra_a), .mem_rdata(mem_a[ra_a]), .rd_data(rdd_a), .rd_empty(emp_a),
    .rd_frame_ready(rdy_a), .rd_truncated(tr_a));

  frame_grab_buf #(.ADDR_W(AW), .DATA_W(DW), .FRAME_WORDS(40)) dut_tr (
    .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_data(pix_data), .mem_we(we_b), .mem_waddr(wa_b), .mem_wdata(wd_b),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_strobe(rd_strobe), .rd_rearm(rd_rearm),
    .mem_raddr(ra_b), .mem_rdata(mem_b[ra_b]), .rd_data(rdd_b), .rd_empty(emp_b),
    .rd_frame_ready(rdy_b), .rd_truncated(tr_b));

  always @(posedge pix_clk) begin
    if (we_a) begin mem_a[wa_a] <= wd_a; wcnt_a <= wcnt_a + 1; end
    if (we_b) begin mem_b[wa_b] <= wd_b; wcnt_b <= wcnt_b + 1; end
  end

  // Word i of frame tag: tag in the top byte, index below; frame 5 opens with zero blanking.
  function automatic logic [DW-1:0] word(input int tag, input int i);
    if (tag == 5 && i < 4) return '0;
    return {tag[7:0], 24'(i)};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int tag, input int n, input int gap, input bit with_sof);
    for (int i = 0; i < n; i++) begin
      @(negedge pix_clk);
      pix_valid = 1; pix_sof = with_sof && (i == 0); pix_data = word(tag, i);
      if (gap != 0 && (i % gap) == gap - 1) begin
        @(negedge pix_clk);
        pix_valid = 0; pix_sof = 0; pix_data = '1;
      end
    end
    @(negedge pix_clk);
    pix_valid = 0; pix_sof = 0;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 200 && !(rdy_a && rdy_b); k++) @(negedge rd_clk);
    chk("R5 frame_ready A", rdy_a, 1'b1);
    chk("R5 frame_ready B", rdy_b, 1'b1);
  endtask

  // Hold strobe high for 'steps' read cycles, checking both copies each cycle.
  task automatic drain(input int tag, input int steps);
    @(negedge rd_clk);
    for (int i = 0; i < steps; i++) begin
      if (i < LEN_A) chk("R5 data A", rdd_a, word(tag, i));
      chk("R6 empty A", emp_a, (i >= LEN_A));
      if (i < LEN_B) chk("R5 data B", rdd_b, word(tag, i));
      chk("R6 empty B", emp_b, (i >= LEN_B));
      rd_strobe = 1;
      @(negedge rd_clk);
    end
    rd_strobe = 0;
  endtask

  task automatic rearm();
    @(negedge rd_clk); rd_rearm = 1;
    @(negedge rd_clk); rd_rearm = 0;
    chk("R8 ready low A", rdy_a, 1'b0);
    chk("R8 ready low B", rdy_b, 1'b0);
    chk("R8 trunc clear B", tr_b, 1'b0);
    repeat (10) @(negedge rd_clk);
  endtask

  initial begin
    repeat (200000) @(posedge pix_clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge rd_clk);
    pix_rst_n = 1; rd_rst_n = 1;
    @(negedge rd_clk);
    // R1 reset state
    chk("R1 ready", rdy_a, 1'b0);
    chk("R1 empty", emp_a, 1'b1);
    chk("R1 trunc", tr_b, 1'b0);
    chk("R1 no write", 32'(wcnt_a + wcnt_b), 0);
    // R7 rearm with nothing held
    rd_rearm = 1; @(negedge rd_clk); rd_rearm = 0;
    repeat (4) @(negedge rd_clk);
    chk("R7 ready stays low", rdy_a, 1'b0);
    // R2 tail of a frame without its start marker
    send_frame(1, 8, 0, 1'b0);
    chk("R2 no write before sof", 32'(wcnt_a), 0);
    // R3 R9 R10 frame with gaps, longer than both memories
    send_frame(2, 40, 3, 1'b1);
    chk("R4 A stops at frame", 32'(wcnt_a), LEN_A);
    chk("R9 B stops at depth", 32'(wcnt_b), LEN_B);
    send_frame(3, 40, 0, 1'b1);
    chk("R4 later frame dropped A", 32'(wcnt_a), LEN_A);
    chk("R4 later frame dropped B", 32'(wcnt_b), LEN_B);
    wait_ready();
    chk("R9 trunc B", tr_b, 1'b1);
    chk("R9 no trunc A", tr_a, 1'b0);
    // R3 R4 R6 drain while another frame streams in, with extra strobes
    fork
      drain(2, LEN_B + 3);
      send_frame(4, 40, 2, 1'b1);
    join
    chk("R6 still held after extra strobes", rdy_a, 1'b1);
    chk("R4 no write during drain", 32'(wcnt_a), LEN_A);
    // R8 rearm after full drain, then R10 frame with zero blanking words
    rearm();
    send_frame(5, 40, 4, 1'b1);
    chk("R8 recapture A", 32'(wcnt_a), 2 * LEN_A);
    wait_ready();
    drain(5, 5);
    // R8 rearm part way through a drain
    rearm();
    send_frame(6, 40, 0, 1'b1);
    wait_ready();
    drain(6, LEN_B + 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule